// File: doc/BRIEF.md
# Atomic Read-Modify-Write Unit

This block sits between several requesting cores and one single-port word store. It turns every request into an indivisible read-then-write sequence on the store, so that compare-and-swap, test-and-set, fetch-and-increment and the load-linked / store-conditional pair need no locking by the cores. Plain loads and stores go through the same path. The word store is held inside the block.

Each core owns a request channel made of a valid/ready handshake, a 3-bit opcode, a word address and two argument words. The core identity is the index of the channel. One shared response channel returns a one-cycle pulse that carries the core index, the word as it was before the operation, and a success flag. When several cores request in the same cycle, a round-robin arbiter picks one and the others wait with ready low. Only one operation is in flight at any time.

Each core has one reservation slot, a valid bit and an address. Load-linked fills the slot. A committed write from any core to the reserved address empties every matching slot, and store-conditional writes only while the issuing core's slot still matches.

Top module: `amo_unit`

## Requirements
- R1: Opcode 0 (load) returns the stored word with no write, opcode 1 (store) writes arg0, and opcode 7 (reserved) acts as a load; all three report ok=1 and return the word held before.
- R2: Opcode 2 (compare-and-swap) writes arg1 only when the stored word equals arg0; ok is 1 when the swap happens and 0 otherwise; the old word is always returned.
- R3: Opcode 3 (test-and-set) writes arg0 unconditionally, returns the previous word and reports ok=1.
- R4: Opcode 4 (fetch-and-increment) stores the old word plus one modulo 2^DATA_W, returns the old word and reports ok=1.
- R5: Opcode 5 (load-linked) returns the word with ok=1, sets the issuing core's reservation to that address, and replaces any reservation the core held before.
- R6: Opcode 6 (store-conditional) writes arg0 and reports ok=1 only when the issuing core's reservation is valid for that address; the issuing core's reservation is empty afterwards whether or not it succeeded.
- R7: A committed write (store, successful compare-and-swap, test-and-set, fetch-and-increment, successful store-conditional) empties every reservation for that address; writes to other addresses and failed compare-and-swap leave reservations intact.
- R8: A store-conditional from a core with no matching reservation reports ok=0 and leaves the stored word unchanged.
- R9: A request is accepted at the clock edge where its valid and ready are both high; rsp_valid is high for exactly one cycle, two cycles after acceptance; during those two cycles every ready is low.
- R10: At most one ready is high, only for a core whose valid is high; after a grant to core g, priority starts at core g+1 and wraps around.
- R11: After reset the arbiter gives core 0 first priority, no reservation is held, and rsp_valid is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | NUM_CORES | Request valid, one bit per core |
| req_ready | output | NUM_CORES | Request accepted this cycle, one bit per core |
| req_op | input | 3*NUM_CORES | Opcode per core, core c in bits [3c+2:3c] |
| req_addr | input | ADDR_W*NUM_CORES | Word address per core |
| req_arg0 | input | DATA_W*NUM_CORES | First argument per core |
| req_arg1 | input | DATA_W*NUM_CORES | Second argument per core |
| rsp_valid | output | 1 | Response pulse |
| rsp_core | output | clog2(NUM_CORES) | Index of the core being answered |
| rsp_old | output | DATA_W | Word held before the operation |
| rsp_ok | output | 1 | Success flag |

## Verification
A corrupted reservation slot shows up at the next store-conditional of that core, as a wrong ok flag and, on a false success, as a wrong word returned by the following read of that address. A wrong arbiter pointer appears on the first cycle with two or more contending cores, as a ready bit for the wrong core. A fault in the read-then-write sequencing shows on the response pulse itself: a late or doubled rsp_valid, or a ready raised while an operation is still in flight, is visible within the two cycles after acceptance.

// File: rtl/amo_pkg.sv
package amo_pkg;
   localparam int OP_W = 3;

   typedef enum logic [OP_W-1:0] {
      AMO_LOAD  = 3'd0,
      AMO_STORE = 3'd1,
      AMO_CAS   = 3'd2,
      AMO_TAS   = 3'd3,
      AMO_FAI   = 3'd4,
      AMO_LL    = 3'd5,
      AMO_SC    = 3'd6,
      AMO_RSVD  = 3'd7
   } amo_op_e;

   typedef enum logic [1:0] {
      PH_IDLE  = 2'd0,
      PH_READ  = 2'd1,
      PH_WRITE = 2'd2
   } amo_phase_e;
endpackage

// File: rtl/amo_rr_arbiter.sv
module amo_rr_arbiter #(
   parameter int N  = 4,
   localparam int CW = (N > 1) ? $clog2(N) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          enable,
   input  logic [N-1:0]  req,
   output logic [N-1:0]  grant,
   output logic [CW-1:0] grant_idx,
   output logic          any_grant
);
   logic [CW-1:0] ptr_q;
   int            idx;

   always_comb begin
      grant     = '0;
      grant_idx = '0;
      any_grant = 1'b0;
      idx       = 0;
      for (int i = 0; i < N; i++) begin
         idx = (int'(ptr_q) + i) % N;
         if (enable && !any_grant && req[idx]) begin
            any_grant  = 1'b1;
            grant[idx] = 1'b1;
            grant_idx  = CW'(idx);
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ptr_q <= '0;
      else if (any_grant)
         ptr_q <= (grant_idx == CW'(N - 1)) ? '0 : grant_idx + CW'(1);
   end
endmodule

// File: rtl/amo_word_store.sv
module amo_word_store #(
   parameter int ADDR_W = 6,
   parameter int DATA_W = 32,
   localparam int DEPTH = 1 << ADDR_W
) (
   input  logic              clk,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_data
);
   logic [DATA_W-1:0] words [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en)
         words[addr] <= wr_data;
   end

   assign rd_data = words[addr];
endmodule

// File: rtl/amo_resv_table.sv
module amo_resv_table #(
   parameter int N      = 4,
   parameter int ADDR_W = 6,
   localparam int CW    = (N > 1) ? $clog2(N) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CW-1:0]     core,
   input  logic [ADDR_W-1:0] addr,
   input  logic              clr_en,
   input  logic              set_en,
   input  logic              drop_en,
   output logic              hit
);
   logic [N-1:0]      slot_vld;
   logic [ADDR_W-1:0] slot_addr [N];

   for (genvar c = 0; c < N; c++) begin : g_slot
      logic              v_q;
      logic [ADDR_W-1:0] a_q;
      logic              mine;

      assign mine = (core == CW'(c));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            v_q <= 1'b0;
            a_q <= '0;
         end else if (set_en && mine) begin
            v_q <= 1'b1;
            a_q <= addr;
         end else if ((drop_en && mine) || (clr_en && v_q && a_q == addr)) begin
            v_q <= 1'b0;
         end
      end

      assign slot_vld[c]  = v_q;
      assign slot_addr[c] = a_q;
   end

   always_comb begin
      hit = 1'b0;
      for (int c = 0; c < N; c++)
         if (core == CW'(c) && slot_vld[c] && slot_addr[c] == addr)
            hit = 1'b1;
   end
endmodule

// File: rtl/amo_op_eval.sv
module amo_op_eval
   import amo_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  amo_op_e           op,
   input  logic [DATA_W-1:0] old_word,
   input  logic [DATA_W-1:0] arg0,
   input  logic [DATA_W-1:0] arg1,
   input  logic              resv_hit,
   output logic              wr_en,
   output logic [DATA_W-1:0] wr_data,
   output logic              ok
);
   always_comb begin
      wr_en   = 1'b0;
      wr_data = old_word;
      ok      = 1'b1;
      unique case (op)
         AMO_STORE, AMO_TAS: begin
            wr_en   = 1'b1;
            wr_data = arg0;
         end
         AMO_CAS: begin
            if (old_word == arg0) begin
               wr_en   = 1'b1;
               wr_data = arg1;
            end else begin
               ok = 1'b0;
            end
         end
         AMO_FAI: begin
            wr_en   = 1'b1;
            wr_data = old_word + DATA_W'(1);
         end
         AMO_SC: begin
            if (resv_hit) begin
               wr_en   = 1'b1;
               wr_data = arg0;
            end else begin
               ok = 1'b0;
            end
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/amo_unit.sv
module amo_unit
   import amo_pkg::*;
#(
   parameter int NUM_CORES = 4,
   parameter int ADDR_W    = 6,
   parameter int DATA_W    = 32,
   localparam int CW       = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [NUM_CORES-1:0]          req_valid,
   output logic [NUM_CORES-1:0]          req_ready,
   input  logic [NUM_CORES*OP_W-1:0]     req_op,
   input  logic [NUM_CORES*ADDR_W-1:0]   req_addr,
   input  logic [NUM_CORES*DATA_W-1:0]   req_arg0,
   input  logic [NUM_CORES*DATA_W-1:0]   req_arg1,
   output logic                          rsp_valid,
   output logic [CW-1:0]                 rsp_core,
   output logic [DATA_W-1:0]             rsp_old,
   output logic                          rsp_ok
);
   initial begin
      if (NUM_CORES < 2)  $fatal(1, "amo_unit: NUM_CORES must be at least 2");
      if (ADDR_W < 1)     $fatal(1, "amo_unit: ADDR_W must be at least 1");
      if (ADDR_W > 12)    $fatal(1, "amo_unit: ADDR_W too large for the inner store");
      if (DATA_W < 2)     $fatal(1, "amo_unit: DATA_W must be at least 2");
   end

   amo_phase_e        phase_q;
   amo_op_e           op_q;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] arg0_q, arg1_q, old_q, wdata_q;
   logic [CW-1:0]     core_q;
   logic              we_q, ok_q;

   logic [NUM_CORES-1:0] grant;
   logic [CW-1:0]        grant_idx;
   logic                 any_grant;

   logic [OP_W-1:0]   sel_op;
   logic [ADDR_W-1:0] sel_addr;
   logic [DATA_W-1:0] sel_arg0, sel_arg1;

   logic [DATA_W-1:0] mem_rdata;
   logic              mem_we;
   logic              resv_hit;
   logic              ev_we, ev_ok;
   logic [DATA_W-1:0] ev_wdata;
   logic              in_write;

   amo_rr_arbiter #(.N(NUM_CORES)) u_arb (
      .clk       (clk),
      .rst_n     (rst_n),
      .enable    (phase_q == PH_IDLE),
      .req       (req_valid),
      .grant     (grant),
      .grant_idx (grant_idx),
      .any_grant (any_grant)
   );

   assign req_ready = grant;

   always_comb begin
      sel_op   = req_op  [int'(grant_idx)*OP_W   +: OP_W];
      sel_addr = req_addr[int'(grant_idx)*ADDR_W +: ADDR_W];
      sel_arg0 = req_arg0[int'(grant_idx)*DATA_W +: DATA_W];
      sel_arg1 = req_arg1[int'(grant_idx)*DATA_W +: DATA_W];
   end

   assign in_write = (phase_q == PH_WRITE);
   assign mem_we   = in_write && we_q;

   amo_word_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
      .clk     (clk),
      .addr    (addr_q),
      .wr_en   (mem_we),
      .wr_data (wdata_q),
      .rd_data (mem_rdata)
   );

   amo_resv_table #(.N(NUM_CORES), .ADDR_W(ADDR_W)) u_resv (
      .clk     (clk),
      .rst_n   (rst_n),
      .core    (core_q),
      .addr    (addr_q),
      .clr_en  (mem_we),
      .set_en  (in_write && op_q == AMO_LL),
      .drop_en (in_write && op_q == AMO_SC),
      .hit     (resv_hit)
   );

   amo_op_eval #(.DATA_W(DATA_W)) u_eval (
      .op       (op_q),
      .old_word (mem_rdata),
      .arg0     (arg0_q),
      .arg1     (arg1_q),
      .resv_hit (resv_hit),
      .wr_en    (ev_we),
      .wr_data  (ev_wdata),
      .ok       (ev_ok)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         op_q    <= AMO_LOAD;
         addr_q  <= '0;
         arg0_q  <= '0;
         arg1_q  <= '0;
         core_q  <= '0;
         old_q   <= '0;
         wdata_q <= '0;
         we_q    <= 1'b0;
         ok_q    <= 1'b0;
      end else begin
         unique case (phase_q)
            PH_IDLE: begin
               if (any_grant) begin
                  op_q    <= amo_op_e'(sel_op);
                  addr_q  <= sel_addr;
                  arg0_q  <= sel_arg0;
                  arg1_q  <= sel_arg1;
                  core_q  <= grant_idx;
                  phase_q <= PH_READ;
               end
            end
            PH_READ: begin
               old_q   <= mem_rdata;
               we_q    <= ev_we;
               wdata_q <= ev_wdata;
               ok_q    <= ev_ok;
               phase_q <= PH_WRITE;
            end
            default: phase_q <= PH_IDLE;
         endcase
      end
   end

   assign rsp_valid = in_write;
   assign rsp_core  = core_q;
   assign rsp_old   = old_q;
   assign rsp_ok    = ok_q;
endmodule

// File: rtl/amo_unit_chk.sv
module amo_unit_chk #(
   parameter int NUM_CORES = 4,
   parameter int ADDR_W    = 6,
   parameter int DATA_W    = 32,
   localparam int CW       = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [NUM_CORES-1:0] req_valid,
   input logic [NUM_CORES-1:0] req_ready,
   input logic                 rsp_valid,
   input logic [CW-1:0]        rsp_core,
   input logic [DATA_W-1:0]    rsp_old,
   input logic                 rsp_ok
);
   logic          accepted;
   logic [CW-1:0] acc_idx;

   assign accepted = |(req_valid & req_ready);

   always_comb begin
      acc_idx = '0;
      for (int c = 0; c < NUM_CORES; c++)
         if (req_ready[c]) acc_idx = CW'(c);
   end

   // R10: never more than one ready
   a_r10_one_ready: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(req_ready));

   // R10: ready only towards a requesting core
   a_r10_ready_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
      (req_ready & ~req_valid) == '0);

   // R9: response two cycles after acceptance
   a_r9_rsp_latency: assert property (@(posedge clk) disable iff (!rst_n)
      accepted |-> ##2 rsp_valid);

   // R9: nothing accepted during the read cycle
   a_r9_busy_read: assert property (@(posedge clk) disable iff (!rst_n)
      accepted |=> (req_ready == '0));

   // R9: nothing accepted during the write cycle
   a_r9_busy_write: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> (req_ready == '0));

   // R9: response is a single-cycle pulse
   a_r9_rsp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);

   // R9: response answers the core accepted two cycles earlier
   a_r9_rsp_core: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> (rsp_core == $past(acc_idx, 2)));

   // R11: reset leaves the response channel quiet
   a_r11_reset_quiet: assert property (@(posedge clk)
      !rst_n |=> !rsp_valid);
endmodule

bind amo_unit amo_unit_chk #(
   .NUM_CORES (NUM_CORES),
   .ADDR_W    (ADDR_W),
   .DATA_W    (DATA_W)
) u_amo_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_ready (req_ready),
   .rsp_valid (rsp_valid),
   .rsp_core  (rsp_core),
   .rsp_old   (rsp_old),
   .rsp_ok    (rsp_ok)
);

// File: tb/test_amo_unit.sv
module test_amo_unit;
   localparam int N  = 3;
   localparam int AW = 4;
   localparam int DW = 8;
   localparam int CW = 2;
   localparam int D  = 1 << AW;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [N-1:0]      req_valid = '0;
   logic [N-1:0]      req_ready;
   logic [N*3-1:0]    req_op = '0;
   logic [N*AW-1:0]   req_addr = '0;
   logic [N*DW-1:0]   req_arg0 = '0;
   logic [N*DW-1:0]   req_arg1 = '0;
   logic              rsp_valid;
   logic [CW-1:0]     rsp_core;
   logic [DW-1:0]     rsp_old;
   logic              rsp_ok;

   amo_unit #(.NUM_CORES(N), .ADDR_W(AW), .DATA_W(DW)) i_amo_unit (
      .clk, .rst_n, .req_valid, .req_ready, .req_op, .req_addr,
      .req_arg0, .req_arg1, .rsp_valid, .rsp_core, .rsp_old, .rsp_ok
   );

   always #10 clk = ~clk;

   int total = 0;
   int fails = 0;
   int ptr_m = 0;
   logic [DW-1:0] mm [D];
   bit  rv [N];
   int  ra [N];

   task automatic chk(bit cond, string req, string what, int act, int exp);
      total++;
      if (!cond) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      total++;
      $display("FAIL watchdog: actual 1 expected 0");
      summary();
   end

   // model from the requirement text
   task automatic model(int c, int op, int a, int x0, int x1,
                        output int e_old, output bit e_ok);
      bit we = 0;
      logic [DW-1:0] wd = '0;
      e_old = int'(mm[a]);
      e_ok  = 1;
      case (op)
         1, 3: begin we = 1; wd = DW'(x0); end
         2: if (mm[a] == DW'(x0)) begin we = 1; wd = DW'(x1); end else e_ok = 0;
         4: begin we = 1; wd = mm[a] + 8'd1; end
         5: begin rv[c] = 1; ra[c] = a; end
         6: begin
            if (rv[c] && ra[c] == a) begin we = 1; wd = DW'(x0); end else e_ok = 0;
            rv[c] = 0;
         end
         default: ;
      endcase
      if (we) begin
         mm[a] = wd;
         for (int k = 0; k < N; k++) if (rv[k] && ra[k] == a) rv[k] = 0;
      end
   endtask

   task automatic one(int c, int op, int a, int x0, int x1, string req);
      int  e_old;
      bit  e_ok;
      @(negedge clk);
      req_op  [c*3 +: 3]   = 3'(op);
      req_addr[c*AW +: AW] = AW'(a);
      req_arg0[c*DW +: DW] = DW'(x0);
      req_arg1[c*DW +: DW] = DW'(x1);
      req_valid[c] = 1'b1;
      #1;
      chk(req_ready == N'(1 << c), "R10", "ready for lone requester", int'(req_ready), 1 << c);
      model(c, op, a, x0, x1, e_old, e_ok);
      ptr_m = (c + 1) % N;
      @(negedge clk);
      req_valid[c] = 1'b0;
      #1;
      chk(!rsp_valid && req_ready == '0, "R9", "busy in read cycle", int'(rsp_valid), 0);
      @(negedge clk);
      #1;
      chk(rsp_valid === 1'b1, "R9", "rsp_valid two cycles after accept", int'(rsp_valid), 1);
      chk(rsp_core == CW'(c), req, "rsp_core", int'(rsp_core), c);
      chk(rsp_old == DW'(e_old), req, "rsp_old", int'(rsp_old), e_old);
      chk(rsp_ok == e_ok, req, "rsp_ok", int'(rsp_ok), int'(e_ok));
   endtask

   task automatic contend(int pat);
      bit pend [N];
      int cnt = 0;
      @(negedge clk);
      for (int c = 0; c < N; c++) begin
         pend[c] = pat[c];
         if (pat[c]) begin
            cnt++;
            req_op  [c*3 +: 3]   = 3'd0;
            req_addr[c*AW +: AW] = AW'(c);
            req_valid[c] = 1'b1;
         end
      end
      for (int k = 0; k < cnt; k++) begin
         int e = -1;
         int g;
         #1;
         for (int i = 0; i < N; i++) begin
            int j = (ptr_m + i) % N;
            if (e < 0 && pend[j]) e = j;
         end
         chk(req_ready == N'(1 << e), "R10", "round-robin grant", int'(req_ready), 1 << e);
         g = e;
         for (int c = 0; c < N; c++) if (req_ready[c]) g = c;
         pend[g] = 0;
         ptr_m = (g + 1) % N;
         @(negedge clk);
         req_valid[g] = 1'b0;
         @(negedge clk);
         #1;
         chk(rsp_valid && rsp_core == CW'(e), "R10", "rsp_core of granted", int'(rsp_core), e);
         @(negedge clk);
      end
   endtask

   initial begin
      for (int c = 0; c < N; c++) begin rv[c] = 0; ra[c] = 0; end
      repeat (3) @(posedge clk);
      @(negedge clk);
      #1;
      chk(rsp_valid == 1'b0, "R11", "rsp_valid in reset", int'(rsp_valid), 0);
      rst_n = 1'b1;
      @(negedge clk);
      #1;
      chk(req_ready == '0 && !rsp_valid, "R11", "idle after reset", int'(req_ready), 0);

      // R11: first contention after reset starts at core 0; R10 sweep of all patterns
      contend(7);
      for (int p = 1; p < 8; p++) contend(p);
      for (int p = 7; p > 0; p--) contend(p);

      // R1: fill and read back every word
      for (int a = 0; a < D; a++) one(a % N, 1, a, (a * 37 + 5) & 255, 0, "R1");
      for (int a = 0; a < D; a++) one((a + 1) % N, 0, a, 0, 0, "R1");
      one(2, 7, 1, 99, 99, "R1");
      one(0, 0, 1, 0, 0, "R1");

      // R2: compare-and-swap, match and mismatch
      one(0, 2, 2, int'(mm[2]), 8'h5A, "R2");
      one(1, 2, 2, 8'h11, 8'h22, "R2");
      one(2, 0, 2, 0, 0, "R2");

      // R3: test-and-set twice
      one(1, 3, 3, 1, 0, "R3");
      one(1, 3, 3, 1, 0, "R3");

      // R4: fetch-and-increment with wrap
      one(0, 1, 4, 8'hFE, 0, "R4");
      one(0, 4, 4, 0, 0, "R4");
      one(1, 4, 4, 0, 0, "R4");
      one(2, 4, 4, 0, 0, "R4");
      one(0, 0, 4, 0, 0, "R4");

      // R5/R6: link, conditional success, then consumed
      one(0, 5, 5, 0, 0, "R5");
      one(0, 6, 5, 8'h77, 0, "R6");
      one(0, 6, 5, 8'h78, 0, "R6");
      one(1, 0, 5, 0, 0, "R6");

      // R7: another core's store breaks the link
      one(1, 5, 6, 0, 0, "R5");
      one(2, 1, 6, 8'h33, 0, "R7");
      one(1, 6, 6, 8'h44, 0, "R7");
      one(0, 0, 6, 0, 0, "R7");

      // R7: write elsewhere leaves the link
      one(2, 5, 7, 0, 0, "R5");
      one(0, 1, 8, 8'h01, 0, "R7");
      one(2, 6, 7, 8'h55, 0, "R7");

      // R7: failed compare-and-swap leaves the link
      one(0, 5, 15, 0, 0, "R5");
      one(1, 2, 15, int'(mm[15]) ^ 1, 8'hAA, "R7");
      one(0, 6, 15, 8'h66, 0, "R7");

      // R8: no reservation at all, then wrong address
      one(0, 6, 9, 8'hEE, 0, "R8");
      one(1, 0, 9, 0, 0, "R8");
      one(1, 5, 10, 0, 0, "R5");
      one(1, 6, 11, 8'hEE, 0, "R8");
      one(2, 0, 11, 0, 0, "R8");

      // R6/R7: two linkers, first success breaks the second
      one(0, 5, 12, 0, 0, "R5");
      one(1, 5, 12, 0, 0, "R5");
      one(0, 6, 12, 8'h12, 0, "R6");
      one(1, 6, 12, 8'h13, 0, "R7");
      one(2, 0, 12, 0, 0, "R6");

      // R5: a newer link replaces the older one
      one(2, 5, 13, 0, 0, "R5");
      one(2, 5, 14, 0, 0, "R5");
      one(2, 6, 14, 8'h14, 0, "R5");
      one(2, 5, 13, 0, 0, "R5");
      one(2, 5, 14, 0, 0, "R5");
      one(2, 6, 13, 8'h15, 0, "R5");
      one(0, 0, 13, 0, 0, "R5");

      summary();
   end
endmodule